// File: doc/BRIEF.md
# Byte Permute-and-XOR Unit

This block combines two 128-bit source vectors under the control of a third. Each of the three vectors holds sixteen bytes, and byte 0 sits in the most significant position of the word. The control byte at a given output position holds two 4-bit selectors. The upper nibble chooses a byte of source A and the lower nibble chooses a byte of source B. The output byte at that position is the XOR of the two chosen bytes.

The sixteen output lanes work in parallel as a combinational datapath. A parameter can add a result register at the output. With the register present, a result is captured when the input valid strobe is high, and the output valid signal goes high on the following cycle. Without the register, the result and the valid signal pass straight through.

Top module: `vperm_xor_unit`

## Requirements
- R1: Operands and the result are 128-bit words of sixteen bytes. Byte k occupies bits [127-8k -: 8], so byte 0 is bits [127:120].
- R2: For output byte k, the A-selector is bits [7:4] of control byte k, with the upper nibble meaning byte 0 of A is at bits [127:120].
- R3: For output byte k, the B-selector is bits [3:0] of control byte k.
- R4: Output byte k equals A[sel_a] XOR B[sel_b]. The two selectors are independent of each other and of the selectors in other lanes.
- R5: With the output register enabled, `res_vec` and `res_vld` update one clock after the edge at which `in_vld` is high. The captured result is the one computed from the operands present at that edge.
- R6: With the output register enabled, `res_vec` holds its value on every cycle where `in_vld` is low, and `res_vld` is low on the next cycle.
- R7: A synchronous active-low reset sets `res_vec` to zero and `res_vld` to low.
- R8: With a = F0 F1 … FF, b = FF EF … 0F and c = 01 23 45 67 89 AB CD EF F0 E1 D2 C3 B4 A5 96 87, the result is 1F 3D 5B 79 97 B5 D3 F1 00 11 22 33 44 55 66 77.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operands valid; captures the result |
| src_a | input | 128 | Source vector A |
| src_b | input | 128 | Source vector B |
| ctl | input | 128 | Control vector: two nibble selectors per byte |
| res_vec | output | 128 | Permute-XOR result |
| res_vld | output | 1 | Result valid |

## Verification
The checker verifies the register timing on every cycle. It checks that `res_vld` follows `in_vld` by one clock, that the result holds while no valid strobe arrives, and that the reset values are correct. It also checks that byte 0 of a registered result matches the value recomputed from the previous cycle's operands.

The correctness of all sixteen lanes is shown only by the bench. It compares each result against a behavioural model using the fixed reference vector, random operands, and directed selector patterns: all selectors zero, all selectors fifteen, and the same byte chosen from both sources.

// File: rtl/vpx_pkg.sv
// Package: shared widths and types for the permute-XOR unit.
// Assumes byte-granular lanes with a power-of-two lane count.
package vpx_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned N_LANES = 16;
    localparam int unsigned SEL_W   = $clog2(N_LANES);
    localparam int unsigned VEC_W   = BYTE_W * N_LANES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // Pair of selectors decoded from one control byte.
    typedef struct packed {
        sel_t sel_a;
        sel_t sel_b;
    } sel_pair_t;
endpackage

// File: rtl/vpx_byte_mux.sv
// Module: vpx_byte_mux
// Picks one byte out of a packed vector by index, with byte 0 in the
// most significant position. Purely combinational.
module vpx_byte_mux #(
    parameter int unsigned N_LANES = 16,
    parameter int unsigned BYTE_W  = 8,
    localparam int unsigned SEL_W  = $clog2(N_LANES),
    localparam int unsigned VEC_W  = N_LANES * BYTE_W
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] out_byte
);
    logic [BYTE_W-1:0] bytes [N_LANES];

    // Split the vector into bytes, most significant byte first.
    for (genvar k = 0; k < N_LANES; k++) begin : g_split
        assign bytes[k] = vec[VEC_W-1-k*BYTE_W -: BYTE_W];
    end

    // Select the indexed byte.
    always_comb begin
        out_byte = bytes[sel];
    end
endmodule

// File: rtl/vpx_lane.sv
// Module: vpx_lane
// One output lane. It decodes the control byte into two nibble
// selectors (upper nibble for A, lower nibble for B) and XORs the bytes
// they choose. Assumes the byte width is twice the selector width.
module vpx_lane
    import vpx_pkg::*;
(
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  byte_t             ctl_byte,
    output byte_t             res_byte
);
    sel_pair_t sp;
    byte_t     pick_a;
    byte_t     pick_b;

    // Decode the control byte into the two selectors.
    always_comb begin
        sp.sel_a = ctl_byte[BYTE_W-1 -: SEL_W];
        sp.sel_b = ctl_byte[SEL_W-1:0];
    end

    vpx_byte_mux #(.N_LANES(N_LANES), .BYTE_W(BYTE_W)) u_mux_a (
        .vec(src_a), .sel(sp.sel_a), .out_byte(pick_a)
    );
    vpx_byte_mux #(.N_LANES(N_LANES), .BYTE_W(BYTE_W)) u_mux_b (
        .vec(src_b), .sel(sp.sel_b), .out_byte(pick_b)
    );

    // Combine the two picked bytes.
    always_comb begin
        res_byte = pick_a ^ pick_b;
    end
endmodule

// File: rtl/vperm_xor_unit.sv
// Module: vperm_xor_unit
// Top level. Sixteen parallel lanes of permute-XOR. With OUT_REG=1 the
// result is captured on in_vld and presented one cycle later with
// res_vld; reset is synchronous and active low. With OUT_REG=0 the
// result and valid are combinational pass-through.
module vperm_xor_unit
    import vpx_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [127:0]     src_a,
    input  logic [127:0]     src_b,
    input  logic [127:0]     ctl,
    output logic [127:0]     res_vec,
    output logic             res_vld
);
    logic [VEC_W-1:0] comb_res;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        vpx_lane u_lane (
            .src_a   (src_a),
            .src_b   (src_b),
            .ctl_byte(ctl[VEC_W-1-k*BYTE_W -: BYTE_W]),
            .res_byte(comb_res[VEC_W-1-k*BYTE_W -: BYTE_W])
        );
    end

    if (OUT_REG) begin : g_reg
        logic [VEC_W-1:0] res_q;
        logic             vld_q;

        // Capture the result on valid input; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_vld;
                if (in_vld) res_q <= comb_res;
            end
        end

        assign res_vec = res_q;
        assign res_vld = vld_q;
    end else begin : g_comb
        assign res_vec = comb_res;
        assign res_vld = in_vld;
    end
endmodule

// File: rtl/vperm_xor_unit_chk.sv
// Module: vperm_xor_unit_chk
// Checker for the registered variant: valid timing, hold, reset, and a
// lane-0 recomputation from the previous cycle's operands.
module vperm_xor_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic [127:0] ctl,
    input logic [127:0] res_vec,
    input logic         res_vld
);
    logic [7:0] lane0_ref;

    // Recompute lane 0 behaviourally by shifting the sources.
    always_comb begin
        lane0_ref = (8'(src_a >> (8 * (15 - int'(ctl[127:124])))))
                  ^ (8'(src_b >> (8 * (15 - int'(ctl[123:120])))));
    end

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld);                                        // R5
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld);                                      // R6
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res_vec));                              // R6
    AST_LANE0_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (res_vec[127:120] == $past(lane0_ref)));         // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res_vec == '0 && !res_vld));                    // R7
endmodule

bind vperm_xor_unit vperm_xor_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_a(src_a),
    .src_b(src_b), .ctl(ctl), .res_vec(res_vec), .res_vld(res_vld)
);

// File: tb/vperm_xor_unit_bench.sv
// Bench: behavioural reference model with a queue of expected results.
// Inputs are driven on the negedge and outputs are checked just before
// the next negedge.
module vperm_xor_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [127:0] src_a = '0, src_b = '0, ctl = '0;
    logic [127:0] res_vec;
    logic         res_vld;

    int n_checks = 0;
    int n_errors = 0;

    logic [127:0] exp_res = '0;
    logic         exp_vld = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vperm_xor_unit u_vperm_xor_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_a(src_a),
        .src_b(src_b), .ctl(ctl), .res_vec(res_vec), .res_vld(res_vld)
    );

    function automatic logic [7:0] get_byte(logic [127:0] v, int k);
        return v[127 - 8*k -: 8];
    endfunction

    function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                           logic [127:0] c);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            int x = int'(get_byte(c, i)) / 16;
            int y = int'(get_byte(c, i)) % 16;
            r[127 - 8*i -: 8] = get_byte(a, x) ^ get_byte(b, y);
        end
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %032h expected %032h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, the model updates at posedge, check before next negedge.
    task automatic step(logic v, logic [127:0] a, logic [127:0] b,
                        logic [127:0] c, string req);
        in_vld = v; src_a = a; src_b = b; ctl = c;
        @(posedge clk);
        exp_vld = v;
        if (v) exp_res = model(a, b, c);
        @(negedge clk);
        check(req, res_vec, exp_res);
        check(req, {127'd0, res_vld}, {127'd0, exp_vld});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [127:0] ra, rb, rc, ident;
        @(negedge clk);
        in_vld = 1'b1; src_a = '1; src_b = '0; ctl = '0;
        @(posedge clk); @(negedge clk);
        // R7: reset clears even with valid asserted
        check("R7", res_vec, '0);
        check("R7", {127'd0, res_vld}, 128'd0);
        in_vld = 1'b0;
        rst_n = 1'b1;

        // R8 / R1: reference vector
        step(1'b1, 128'hF0F1F2F3F4F5F6F7F8F9FAFBFCFDFEFF,
                   128'hFFEFDFCFBFAF9F8F7F6F5F4F3F2F1F0F,
                   128'h0123456789ABCDEFF0E1D2C3B4A59687, "R8");
        check("R8", res_vec, 128'h1F3D5B7997B5D3F1_0011223344556677);
        // R6: hold with valid low while inputs change
        step(1'b0, '1, '1, '1, "R6");
        check("R6", res_vec, 128'h1F3D5B7997B5D3F1_0011223344556677);

        for (int k = 0; k < 16; k++) ident[127 - 8*k -: 8] = 8'(k * 17);
        // R2: select A only (B is zero), the A-selector is the upper nibble
        step(1'b1, ident, '0, 128'hF0E0D0C0B0A090807060504030201000, "R2");
        check("R2", res_vec, 128'hFFEEDDCCBBAA99887766554433221100);
        // R3: select B only, the B-selector is the lower nibble
        step(1'b1, '0, ident, 128'h0F0E0D0C0B0A09080706050403020100, "R3");
        check("R3", res_vec, 128'hFFEEDDCCBBAA99887766554433221100);
        // R4: same byte from both sources cancels out
        step(1'b1, ident, ident, 128'h33333333333333333333333333333333, "R4");
        check("R4", res_vec, '0);
        // R4: all selectors at zero and at fifteen
        step(1'b1, ident, ~ident, '0, "R4");
        step(1'b1, ident, ~ident, '1, "R4");
        // R5: back-to-back and random vectors with gaps
        for (int n = 0; n < 300; n++) begin
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            rc = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom % 4) != 0, ra, rb, rc, "R5");
        end
        // R7: mid-run reset
        rst_n = 1'b0; in_vld = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R7", res_vec, '0);
        check("R7", {127'd0, res_vld}, 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule